// File: doc/BRIEF.md
# SIMD Bitwise Logic and Test Unit

This block is the logic slice of a vector datapath. It takes two 256-bit operands and a 3-bit operation code. It returns either a bitwise combination of the operands or a zero/carry flag pair. The pair comes from two masked products: `a & b` for the zero flag and `(~a) & b` for the carry flag.

The flags are reduced over one of three bit sets, chosen by a test-mode input:
- all 256 bits;
- only the top bit of each 32-bit lane;
- only the top bit of each 64-bit lane.

A flag select routes the zero flag, the carry flag or a "neither set" indication to a one-bit scalar output. Both flags are always exported on their own pins as well.

An optional register stage, enabled by default, captures the data, the flags and the scalar bit together. A valid bit travels alongside them, one cycle behind the input valid.

Top module: `simd_logic_test_unit`

## Requirements
- R1: Operation code 0 gives `result = a & b`.
- R2: Operation code 1 gives `result = (~a) & b`, which inverts the first operand and not the second.
- R3: Operation code 2 gives `result = a | b`.
- R4: Operation code 3 gives `result = a ^ b`.
- R5: Operation code 4 (test) drives `result` to all zeros, and so do the unassigned codes 5, 6 and 7.
- R6: In test mode 0, and in the unassigned mode 3, `zero_flag` is 1 exactly when `a & b` is zero over all 256 bits.
- R7: In test mode 0, and in the unassigned mode 3, `carry_flag` is 1 exactly when `(~a) & b` is zero over all 256 bits.
- R8: In test mode 2, both flags examine only bits 63, 127, 191 and 255 of their products.
- R9: In test mode 1, both flags examine only bit 32k+31 of their products, for k = 0 to 7.
- R10: `test_bit` depends on `flag_sel` as follows:
  - 0 gives `zero_flag`;
  - 1 gives `carry_flag`;
  - 2 gives 1 only when both flags are 0;
  - 3 gives 0.
- R11: Both flags are computed and exported for every operation code and every `flag_sel` value.
- R12: With the register stage enabled:
  - every output appears one clock after its inputs;
  - `out_valid` equals `in_valid` from the previous cycle;
  - synchronous reset clears all outputs to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input qualifier |
| opnd_a | input | 256 | First operand (the one inverted by AND-NOT) |
| opnd_b | input | 256 | Second operand |
| op_sel | input | 3 | Operation code |
| test_mode | input | 2 | Flag reduction set: 0 all bits, 1 32-bit sign bits, 2 64-bit sign bits |
| flag_sel | input | 2 | Scalar output select |
| out_valid | output | 1 | Output qualifier |
| result | output | 256 | Bitwise result, zero during test |
| zero_flag | output | 1 | Zero flag from `a & b` |
| carry_flag | output | 1 | Carry flag from `(~a) & b` |
| test_bit | output | 1 | Selected flag or flag combination |

## Verification
The clocked assertions assume that the inputs are stable and known at each rising edge, and that reset is held for at least one edge before any check counts. The bench meets both conditions by changing inputs only on falling edges and by holding reset for several cycles first.

The assertion on the zero-b case assumes nothing about `test_mode`, because both products are zero whichever bits are examined. The stimulus therefore sweeps every mode and flag select, including the unassigned codes.

The operands mix random values with the patterns that separate the reduction sets:
- all zeros;
- all ones;
- sign bits only;
- non-sign bits only.

// File: rtl/slt_pkg.sv
package slt_pkg;
  typedef enum logic [2:0] {
    OP_AND  = 3'd0,
    OP_ANDN = 3'd1,
    OP_OR   = 3'd2,
    OP_XOR  = 3'd3,
    OP_TEST = 3'd4
  } op_e;

  typedef enum logic [1:0] {
    TM_FULL   = 2'd0,
    TM_SIGN32 = 2'd1,
    TM_SIGN64 = 2'd2
  } tmode_e;

  typedef enum logic [1:0] {
    FS_ZERO  = 2'd0,
    FS_CARRY = 2'd1,
    FS_NONE  = 2'd2
  } fsel_e;
endpackage

// File: rtl/slt_bitop.sv
module slt_bitop
  import slt_pkg::*;
#(
  parameter int DATA_W = 256
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic [2:0]        op,
  output logic [DATA_W-1:0] res
);
  always_comb begin
    case (op_e'(op))
      OP_AND:  res = a & b;
      OP_ANDN: res = (~a) & b;
      OP_OR:   res = a | b;
      OP_XOR:  res = a ^ b;
      default: res = '0;
    endcase
  end
endmodule

// File: rtl/slt_lane_mask.sv
module slt_lane_mask
  import slt_pkg::*;
#(
  parameter int DATA_W   = 256,
  parameter int NARROW_W = 32,
  parameter int WIDE_W   = 64
) (
  input  logic [1:0]        mode,
  output logic [DATA_W-1:0] mask
);
  localparam int N_NARROW = DATA_W / NARROW_W;
  localparam int N_WIDE   = DATA_W / WIDE_W;

  logic [DATA_W-1:0] m_narrow, m_wide;

  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    assign m_narrow[i] = ((i % NARROW_W) == NARROW_W - 1);
    assign m_wide[i]   = ((i % WIDE_W) == WIDE_W - 1);
  end

  always_comb begin
    case (tmode_e'(mode))
      TM_SIGN32: mask = m_narrow;
      TM_SIGN64: mask = m_wide;
      default:   mask = '1;
    endcase
  end

  // R8 R9
  always_comb begin
    mask_pop_chk: assert ($countones(mask) == DATA_W || $countones(mask) == N_NARROW
                          || $countones(mask) == N_WIDE);
  end
endmodule

// File: rtl/slt_flag_reduce.sv
module slt_flag_reduce #(
  parameter int DATA_W = 256
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic [DATA_W-1:0] mask,
  output logic              zf,
  output logic              cf
);
  logic [DATA_W-1:0] and_prod, andn_prod;

  assign and_prod  = a & b & mask;
  assign andn_prod = (~a) & b & mask;
  assign zf = ~|and_prod;
  assign cf = ~|andn_prod;

  // R6 R7: both products empty means b has no tested bit set
  always_comb begin
    if (zf && cf) begin
      both_flags_chk: assert ((b & mask) == '0);
    end
  end
endmodule

// File: rtl/simd_logic_test_unit.sv
module simd_logic_test_unit
  import slt_pkg::*;
#(
  parameter int DATA_W   = 256,
  parameter int NARROW_W = 32,
  parameter int WIDE_W   = 64,
  parameter bit OUT_REG  = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_b,
  input  logic [2:0]        op_sel,
  input  logic [1:0]        test_mode,
  input  logic [1:0]        flag_sel,
  output logic              out_valid,
  output logic [DATA_W-1:0] result,
  output logic              zero_flag,
  output logic              carry_flag,
  output logic              test_bit
);
  logic [DATA_W-1:0] mask_c, res_c;
  logic              zf_c, cf_c, tb_c;

  slt_bitop #(.DATA_W(DATA_W)) u_bitop (
    .a(opnd_a), .b(opnd_b), .op(op_sel), .res(res_c)
  );

  slt_lane_mask #(.DATA_W(DATA_W), .NARROW_W(NARROW_W), .WIDE_W(WIDE_W)) u_mask (
    .mode(test_mode), .mask(mask_c)
  );

  slt_flag_reduce #(.DATA_W(DATA_W)) u_reduce (
    .a(opnd_a), .b(opnd_b), .mask(mask_c), .zf(zf_c), .cf(cf_c)
  );

  always_comb begin
    case (fsel_e'(flag_sel))
      FS_ZERO:  tb_c = zf_c;
      FS_CARRY: tb_c = cf_c;
      FS_NONE:  tb_c = ~zf_c & ~cf_c;
      default:  tb_c = 1'b0;
    endcase
  end

  if (OUT_REG) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        out_valid  <= 1'b0;
        result     <= '0;
        zero_flag  <= 1'b0;
        carry_flag <= 1'b0;
        test_bit   <= 1'b0;
      end else begin
        out_valid  <= in_valid;
        result     <= res_c;
        zero_flag  <= zf_c;
        carry_flag <= cf_c;
        test_bit   <= tb_c;
      end
    end

    // R12
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
      !rst |=> out_valid == $past(in_valid));

    // R5
    test_zero_data_chk: assert property (@(posedge clk) disable iff (rst)
      op_sel == 3'd4 |=> result == '0);

    // R10
    neither_sel_chk: assert property (@(posedge clk) disable iff (rst)
      flag_sel == 2'd2 |=> test_bit == (!zero_flag && !carry_flag));

    // R11
    zero_b_flags_chk: assert property (@(posedge clk) disable iff (rst)
      opnd_b == '0 |=> zero_flag && carry_flag);
  end else begin : g_comb
    assign out_valid  = in_valid;
    assign result     = res_c;
    assign zero_flag  = zf_c;
    assign carry_flag = cf_c;
    assign test_bit   = tb_c;
  end
endmodule

// File: tb/test_simd_logic_test_unit.sv
module test_simd_logic_test_unit;
  localparam int W = 256;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic         rst, in_valid;
  logic [W-1:0] opnd_a, opnd_b, result;
  logic [2:0]   op_sel;
  logic [1:0]   test_mode, flag_sel;
  logic         out_valid, zero_flag, carry_flag, test_bit;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  simd_logic_test_unit i_simd_logic_test_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .opnd_a(opnd_a), .opnd_b(opnd_b),
    .op_sel(op_sel), .test_mode(test_mode), .flag_sel(flag_sel),
    .out_valid(out_valid), .result(result), .zero_flag(zero_flag),
    .carry_flag(carry_flag), .test_bit(test_bit)
  );

  task automatic chk(string tag, string what, logic [W-1:0] act, logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [W-1:0] ref_res(logic [W-1:0] a, logic [W-1:0] b, logic [2:0] op);
    logic [W-1:0] r = '0;
    for (int i = 0; i < W; i++) begin
      case (op)
        3'd0: r[i] = a[i] && b[i];
        3'd1: r[i] = !a[i] && b[i];
        3'd2: r[i] = a[i] || b[i];
        3'd3: r[i] = a[i] != b[i];
        default: r[i] = 1'b0;
      endcase
    end
    return r;
  endfunction

  function automatic logic [W-1:0] ref_mask(logic [1:0] mode);
    logic [W-1:0] m = '0;
    if (mode == 2'd1) for (int k = 0; k < 8; k++) m[32*k+31] = 1'b1;
    else if (mode == 2'd2) for (int k = 0; k < 4; k++) m[64*k+63] = 1'b1;
    else m = '1;
    return m;
  endfunction

  function automatic logic [W-1:0] rnd256();
    logic [W-1:0] v;
    for (int k = 0; k < 8; k++) v[32*k +: 32] = $urandom;
    return v;
  endfunction

  task automatic run(logic [W-1:0] a, logic [W-1:0] b, logic [2:0] op,
                     logic [1:0] mode, logic [1:0] fs, logic vld);
    logic [W-1:0] m;
    logic ez, ec, et;
    string rtag, ftag_z, ftag_c;
    opnd_a = a; opnd_b = b; op_sel = op; test_mode = mode; flag_sel = fs; in_valid = vld;
    m  = ref_mask(mode);
    ez = ((a & b & m) == '0);
    ec = ((~a & b & m) == '0);
    case (fs)
      2'd0: et = ez;
      2'd1: et = ec;
      2'd2: et = !ez && !ec;
      default: et = 1'b0;
    endcase
    case (op)
      3'd0: rtag = "R1";
      3'd1: rtag = "R2";
      3'd2: rtag = "R3";
      3'd3: rtag = "R4";
      default: rtag = "R5";
    endcase
    if (mode == 2'd1) begin ftag_z = "R9"; ftag_c = "R9"; end
    else if (mode == 2'd2) begin ftag_z = "R8"; ftag_c = "R8"; end
    else begin ftag_z = "R6"; ftag_c = "R7"; end
    @(negedge clk);
    chk(rtag, "result", result, ref_res(a, b, op));
    chk(ftag_z, "zero_flag", W'(zero_flag), W'(ez));
    chk(ftag_c, "carry_flag", W'(carry_flag), W'(ec));
    chk("R10", "test_bit", W'(test_bit), W'(et));
    chk("R12", "out_valid", W'(out_valid), W'(vld));
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL R12 watchdog act=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] sgn32, sgn64;
    void'($urandom(32'd20240611));
    sgn32 = ref_mask(2'd1);
    sgn64 = ref_mask(2'd2);
    rst = 1'b1; in_valid = 1'b1; opnd_a = '1; opnd_b = '1;
    op_sel = 3'd2; test_mode = 2'd0; flag_sel = 2'd0;
    repeat (3) @(negedge clk);
    // R12 reset state
    chk("R12", "reset result", result, '0);
    chk("R12", "reset flags", W'({out_valid, zero_flag, carry_flag, test_bit}), '0);
    rst = 1'b0;

    // R2 AND-NOT direction: a ones, b zeros vs a zeros, b ones
    run('1, '0, 3'd1, 2'd0, 2'd0, 1'b1);
    run('0, '1, 3'd1, 2'd0, 2'd1, 1'b1);
    // R6 R7 full vector corners
    run('0, '0, 3'd4, 2'd0, 2'd2, 1'b1);
    run('1, '1, 3'd4, 2'd0, 2'd0, 1'b1);
    run(sgn32, ~sgn32, 3'd4, 2'd0, 2'd2, 1'b1);
    // R9 sign-32: non-sign bits only are invisible
    run(~sgn32, ~sgn32, 3'd4, 2'd1, 2'd0, 1'b1);
    run(sgn32, sgn32, 3'd4, 2'd1, 2'd1, 1'b1);
    run(W'(1) << 95, sgn32, 3'd4, 2'd1, 2'd2, 1'b1);
    // R8 sign-64: bit 31 ignored, bit 191 seen
    run(sgn32, sgn32 & ~sgn64, 3'd4, 2'd2, 2'd0, 1'b1);
    run('0, W'(1) << 191, 3'd4, 2'd2, 2'd1, 1'b1);
    run(sgn64, sgn64, 3'd4, 2'd2, 2'd2, 1'b1);
    // R11 flags exported under a logic op with every select
    run(sgn64, '1, 3'd0, 2'd2, 2'd3, 1'b1);
    run(W'(5), W'(6), 3'd3, 2'd3, 2'd1, 1'b1);
    // R5 unassigned op codes
    run('1, '1, 3'd7, 2'd0, 2'd0, 1'b1);
    // R12 valid low passes through
    run(rnd256(), rnd256(), 3'd2, 2'd0, 2'd0, 1'b0);

    for (int n = 0; n < 400; n++) begin
      logic [W-1:0] a, b;
      a = rnd256();
      b = rnd256();
      case ($urandom_range(0, 3))
        0: b = b & sgn32;
        1: a = a | ~sgn64;
        default: ;
      endcase
      run(a, b, 3'($urandom_range(0, 7)), 2'($urandom_range(0, 3)),
          2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)));
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule